// File: doc/BRIEF.md
# Dual Byte FIFO with Trigger-Level Requests

This block sits between a serial-port register interface and its bit shifter. It holds two independent 64-byte queues. The transmit queue is filled by the processor and drained by the shifter. The receive queue is filled by the shifter and drained by the processor.

Each direction has an 8-bit trigger level, held in a control word. Each level drives a request flag:

- The transmit request asks for more data once the queue has drained to its level.
- The receive request asks for service once the queue has filled to its level.

The control word also carries one flush bit per queue. A flush bit is set by a write and clears itself once its queue has been emptied. One status word reports the occupancy of both queues. Four sticky error flags record pushes that hit a full queue and pops that hit an empty one. Each error flag is cleared by writing one to it.

Top module: `fifo_pair_trig`

## Requirements
- R1: After reset, both queues are empty, the control word and the status word read zero, and all error flags are clear. At a trigger level of zero, both request flags are high.
- R2: Each queue holds up to 64 bytes and returns them in push order. The status word carries the transmit occupancy in bits 23:16 and the receive occupancy in bits 7:0; all other status bits are zero.
- R3: A push to a full queue is discarded and leaves the occupancy unchanged. The push sets that queue's overrun flag: `err_flags` bit 0 for transmit, bit 2 for receive.
- R4: A pop from an empty queue presents data 0 and leaves the occupancy at zero. The pop sets that queue's underrun flag: `err_flags` bit 1 for transmit, bit 3 for receive.
- R5: Writing one to a bit of `err_clr` clears the matching error flag at the next edge. If a new error event arrives in the same cycle, the flag stays set.
- R6: `tx_req` is high whenever transmit occupancy is at or below the transmit level, which is control bits 23:16.
- R7: `rx_req` is high whenever receive occupancy is at or above the receive level, which is control bits 7:0.
- R8: A control write with bit 31 set flushes the transmit queue; one with bit 15 set flushes the receive queue. The flush bit reads back as 1 for the one cycle after the write. At the following edge, the queue is empty and the bit reads 0. The level fields keep the values written, so a flush-only write leaves the control word reading all zero.
- R9: `tx_full`/`rx_full` are high exactly at 64 entries, and `tx_empty`/`rx_empty` are high exactly at zero.
- R10: A push and a pop on the same queue in one cycle, when the queue is neither empty nor full, leave its occupancy unchanged and keep the order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control word write data |
| ctl_rdata | output | 32 | Control word read-back |
| sts_word | output | 32 | Occupancy status word |
| cpu_tx_push | input | 1 | Processor push into the transmit queue |
| cpu_tx_byte | input | 8 | Byte pushed into the transmit queue |
| cpu_rx_pop | input | 1 | Processor pop from the receive queue |
| cpu_rx_byte | output | 8 | Head of the receive queue (0 when empty) |
| shf_tx_pop | input | 1 | Shifter pop from the transmit queue |
| shf_tx_byte | output | 8 | Head of the transmit queue (0 when empty) |
| shf_rx_push | input | 1 | Shifter push into the receive queue |
| shf_rx_byte | input | 8 | Byte pushed into the receive queue |
| err_clr | input | 4 | Write-one-to-clear strobes for the error flags |
| err_flags | output | 4 | Sticky error flags {rx underrun, rx overrun, tx underrun, tx overrun} |
| tx_full | output | 1 | Transmit queue full |
| tx_empty | output | 1 | Transmit queue empty |
| tx_req | output | 1 | Transmit request (occupancy at or below level) |
| rx_full | output | 1 | Receive queue full |
| rx_empty | output | 1 | Receive queue empty |
| rx_req | output | 1 | Receive request (occupancy at or above level) |

## Verification
The head byte of each queue is combinational, so the bench compares it before the clock edge that consumes it. A push, pop, error clear or control write becomes visible in the occupancy, full/empty flags, request flags, error flags and level fields one edge after its strobe, and the bench samples just after that edge. The flush is due two edges after its write: the bench first checks the one-cycle echo of the flush bit, then the empty queue and the cleared bit one edge later. A scoreboard queue per direction mirrors accepted pushes and flushes and supplies the expected byte on every pop, or 0 when it is empty.

// File: rtl/fifo_pair_pkg.sv
// Shared constants for the dual trigger-level FIFO block.
// Assumes the occupancy of a queue fits in an 8-bit status field.
package fifo_pair_pkg;
    localparam int FP_DEPTH       = 64;
    localparam int FP_DW          = 8;
    localparam int FP_LVLW        = 8;
    localparam int FP_WORDW       = 32;

    // Control word layout (software decodes these positions)
    localparam int CTL_TX_FLUSH   = 31;
    localparam int CTL_RX_FLUSH   = 15;
    localparam int CTL_TX_LVL_LSB = 16;
    localparam int CTL_RX_LVL_LSB = 0;

    // Status word layout
    localparam int STS_TX_CNT_LSB = 16;
    localparam int STS_RX_CNT_LSB = 0;

    // Error flag positions
    localparam int ERR_TX_OVF     = 0;
    localparam int ERR_TX_UDR     = 1;
    localparam int ERR_RX_OVF     = 2;
    localparam int ERR_RX_UDR     = 3;
    localparam int ERR_W          = 4;
endpackage

// File: rtl/fp_byte_fifo.sv
// Circular byte queue with occupancy counter, flush and error pulses.
// Head data is combinational and reads 0 when empty. A push to a full
// queue or a pop from an empty one is dropped and pulses an event.
// A flush empties the queue at the next edge and masks other operations.
module fp_byte_fifo #(
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty,
    output logic          ovf_pulse,
    output logic          udr_pulse
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic          wr_ok;
    logic          rd_ok;

    function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    // Queue status and accepted operations
    always_comb begin
        full      = (count == CW'(DEPTH));
        empty     = (count == '0);
        wr_ok     = wr_en && !full  && !flush;
        rd_ok     = rd_en && !empty && !flush;
        ovf_pulse = wr_en && full  && !flush;
        udr_pulse = rd_en && empty && !flush;
        rd_data   = empty ? '0 : mem[rd_ptr];
    end

    // Storage write, no reset needed on the array
    always_ff @(posedge clk) begin
        if (wr_ok) mem[wr_ptr] <= wr_data;
    end

    // Pointer and occupancy update
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_ok) wr_ptr <= ptr_next(wr_ptr);
            if (rd_ok) rd_ptr <= ptr_next(rd_ptr);
            case ({wr_ok, rd_ok})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/fp_level_req.sv
// Compares a queue occupancy against an 8-bit trigger level.
// AT_OR_ABOVE=1 raises req when count >= level (drain request),
// AT_OR_ABOVE=0 raises req when count <= level (fill request).
module fp_level_req #(
    parameter int CW          = 7,
    parameter int LW          = 8,
    parameter bit AT_OR_ABOVE = 1'b0,
    localparam int MW         = (CW > LW) ? CW : LW
) (
    input  logic [CW-1:0] count,
    input  logic [LW-1:0] level,
    output logic          req
);
    logic [MW-1:0] cnt_ext;
    logic [MW-1:0] lvl_ext;

    // Bring both operands to a common width
    always_comb begin
        cnt_ext = MW'(count);
        lvl_ext = MW'(level);
    end

    generate
        if (AT_OR_ABOVE) begin : g_ge
            // Request when the queue has filled to the level
            always_comb req = (cnt_ext >= lvl_ext);
        end else begin : g_le
            // Request when the queue has drained to the level
            always_comb req = (cnt_ext <= lvl_ext);
        end
    endgenerate
endmodule

// File: rtl/fp_ctrl_reg.sv
// Control word: two trigger levels and two self-clearing flush bits.
// A flush bit is high for exactly the cycle after the write that set it.
module fp_ctrl_reg
    import fifo_pair_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [FP_WORDW-1:0] wdata,
    output logic [FP_LVLW-1:0] tx_lvl,
    output logic [FP_LVLW-1:0] rx_lvl,
    output logic               tx_flush,
    output logic               rx_flush,
    output logic [FP_WORDW-1:0] rdata
);
    logic unused_wbits;

    // Level fields hold their value until rewritten
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_lvl <= '0;
            rx_lvl <= '0;
        end else if (we) begin
            tx_lvl <= wdata[CTL_TX_LVL_LSB +: FP_LVLW];
            rx_lvl <= wdata[CTL_RX_LVL_LSB +: FP_LVLW];
        end
    end

    // Flush bits live for one cycle, then clear themselves
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_flush <= 1'b0;
            rx_flush <= 1'b0;
        end else begin
            tx_flush <= we && wdata[CTL_TX_FLUSH];
            rx_flush <= we && wdata[CTL_RX_FLUSH];
        end
    end

    // Read-back assembly, unused positions read zero
    always_comb begin
        rdata = '0;
        rdata[CTL_TX_LVL_LSB +: FP_LVLW] = tx_lvl;
        rdata[CTL_RX_LVL_LSB +: FP_LVLW] = rx_lvl;
        rdata[CTL_TX_FLUSH]              = tx_flush;
        rdata[CTL_RX_FLUSH]              = rx_flush;
    end

    assign unused_wbits = ^{wdata[30:24], wdata[14:8]};
endmodule

// File: rtl/fp_sticky.sv
// Bank of sticky flags: set by event pulses, cleared by write-one strobes.
// A set in the same cycle as a clear wins.
module fp_sticky #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] q
);
    // Per-bit set/clear update
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= (q & ~clr) | set;
    end
endmodule

// File: rtl/fifo_pair_trig.sv
// Transmit and receive byte queues with trigger-level requests.
// The processor pushes transmit data and pops receive data; the shifter
// does the opposite. Control word: levels and flush bits. Status word:
// both occupancies. Error flags are sticky and write-one-to-clear.
module fifo_pair_trig
    import fifo_pair_pkg::*;
#(
    parameter int DEPTH = FP_DEPTH,
    parameter int DW    = FP_DW,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_we,
    input  logic [31:0]   ctl_wdata,
    output logic [31:0]   ctl_rdata,
    output logic [31:0]   sts_word,
    input  logic          cpu_tx_push,
    input  logic [DW-1:0] cpu_tx_byte,
    input  logic          cpu_rx_pop,
    output logic [DW-1:0] cpu_rx_byte,
    input  logic          shf_tx_pop,
    output logic [DW-1:0] shf_tx_byte,
    input  logic          shf_rx_push,
    input  logic [DW-1:0] shf_rx_byte,
    input  logic [3:0]    err_clr,
    output logic [3:0]    err_flags,
    output logic          tx_full,
    output logic          tx_empty,
    output logic          tx_req,
    output logic          rx_full,
    output logic          rx_empty,
    output logic          rx_req
);
    logic [FP_LVLW-1:0] tx_lvl;
    logic [FP_LVLW-1:0] rx_lvl;
    logic               tx_flush;
    logic               rx_flush;
    logic [CW-1:0]      tx_cnt;
    logic [CW-1:0]      rx_cnt;
    logic               tx_ovf;
    logic               tx_udr;
    logic               rx_ovf;
    logic               rx_udr;
    logic [ERR_W-1:0]   err_set;

    fp_ctrl_reg u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (ctl_we),
        .wdata    (ctl_wdata),
        .tx_lvl   (tx_lvl),
        .rx_lvl   (rx_lvl),
        .tx_flush (tx_flush),
        .rx_flush (rx_flush),
        .rdata    (ctl_rdata)
    );

    fp_byte_fifo #(.DEPTH(DEPTH), .DW(DW)) u_txq (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (tx_flush),
        .wr_en     (cpu_tx_push),
        .wr_data   (cpu_tx_byte),
        .rd_en     (shf_tx_pop),
        .rd_data   (shf_tx_byte),
        .count     (tx_cnt),
        .full      (tx_full),
        .empty     (tx_empty),
        .ovf_pulse (tx_ovf),
        .udr_pulse (tx_udr)
    );

    fp_byte_fifo #(.DEPTH(DEPTH), .DW(DW)) u_rxq (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (rx_flush),
        .wr_en     (shf_rx_push),
        .wr_data   (shf_rx_byte),
        .rd_en     (cpu_rx_pop),
        .rd_data   (cpu_rx_byte),
        .count     (rx_cnt),
        .full      (rx_full),
        .empty     (rx_empty),
        .ovf_pulse (rx_ovf),
        .udr_pulse (rx_udr)
    );

    fp_level_req #(.CW(CW), .LW(FP_LVLW), .AT_OR_ABOVE(1'b0)) u_txreq (
        .count (tx_cnt),
        .level (tx_lvl),
        .req   (tx_req)
    );

    fp_level_req #(.CW(CW), .LW(FP_LVLW), .AT_OR_ABOVE(1'b1)) u_rxreq (
        .count (rx_cnt),
        .level (rx_lvl),
        .req   (rx_req)
    );

    // Gather error events into flag positions
    always_comb begin
        err_set             = '0;
        err_set[ERR_TX_OVF] = tx_ovf;
        err_set[ERR_TX_UDR] = tx_udr;
        err_set[ERR_RX_OVF] = rx_ovf;
        err_set[ERR_RX_UDR] = rx_udr;
    end

    fp_sticky #(.N(ERR_W)) u_err (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (err_set),
        .clr   (err_clr),
        .q     (err_flags)
    );

    // Status word assembly
    always_comb begin
        sts_word = '0;
        sts_word[STS_TX_CNT_LSB +: 8] = 8'(tx_cnt);
        sts_word[STS_RX_CNT_LSB +: 8] = 8'(rx_cnt);
    end
endmodule

// File: rtl/fifo_pair_chk.sv
// Temporal checks on the dual FIFO, attached to every instance by bind.
module fifo_pair_chk #(
    parameter int DEPTH = 64
) (
    input logic        clk,
    input logic        rst_n,
    input logic        ctl_we,
    input logic [31:0] ctl_wdata,
    input logic [31:0] ctl_rdata,
    input logic [31:0] sts_word,
    input logic        cpu_tx_push,
    input logic        shf_tx_pop,
    input logic        shf_rx_push,
    input logic        cpu_rx_pop,
    input logic [3:0]  err_clr,
    input logic [3:0]  err_flags,
    input logic        tx_full,
    input logic        tx_empty,
    input logic        tx_req,
    input logic        rx_full,
    input logic        rx_empty
);
    a_r3_tx_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_full && cpu_tx_push && !ctl_rdata[31]) |=> err_flags[0]);

    a_r3_tx_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_full && cpu_tx_push && !shf_tx_pop && !ctl_rdata[31]) |=> tx_full);

    a_r3_rx_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && shf_rx_push && !ctl_rdata[15]) |=> err_flags[2]);

    a_r4_tx_underrun: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_empty && shf_tx_pop && !ctl_rdata[31]) |=> err_flags[1]);

    a_r4_rx_underrun: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_empty && cpu_rx_pop && !ctl_rdata[15]) |=> err_flags[3]);

    a_r5_clear_tx_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr[0] && !(tx_full && cpu_tx_push && !ctl_rdata[31])) |=> !err_flags[0]);

    a_r8_tx_flush: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_rdata[31] && !(ctl_we && ctl_wdata[31])) |=> (sts_word[23:16] == 8'd0 && !ctl_rdata[31]));

    a_r8_rx_flush: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_rdata[15] && !(ctl_we && ctl_wdata[15])) |=> (sts_word[7:0] == 8'd0 && !ctl_rdata[15]));

    a_r2_occupancy_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_word[23:16] <= 8'(DEPTH)) && (sts_word[7:0] <= 8'(DEPTH)));

    a_r9_full_empty_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_full && tx_empty) && !(rx_full && rx_empty));

    a_r6_empty_requests: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> tx_req);
endmodule

bind fifo_pair_trig fifo_pair_chk #(.DEPTH(DEPTH)) u_fifo_pair_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl_we      (ctl_we),
    .ctl_wdata   (ctl_wdata),
    .ctl_rdata   (ctl_rdata),
    .sts_word    (sts_word),
    .cpu_tx_push (cpu_tx_push),
    .shf_tx_pop  (shf_tx_pop),
    .shf_rx_push (shf_rx_push),
    .cpu_rx_pop  (cpu_rx_pop),
    .err_clr     (err_clr),
    .err_flags   (err_flags),
    .tx_full     (tx_full),
    .tx_empty    (tx_empty),
    .tx_req      (tx_req),
    .rx_full     (rx_full),
    .rx_empty    (rx_empty)
);

// File: tb/tb_fifo_pair_trig.sv
module tb_fifo_pair_trig;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_we = 1'b0;
    logic [31:0] ctl_wdata = '0;
    logic [31:0] ctl_rdata;
    logic [31:0] sts_word;
    logic        cpu_tx_push = 1'b0;
    logic [7:0]  cpu_tx_byte = '0;
    logic        cpu_rx_pop = 1'b0;
    logic [7:0]  cpu_rx_byte;
    logic        shf_tx_pop = 1'b0;
    logic [7:0]  shf_tx_byte;
    logic        shf_rx_push = 1'b0;
    logic [7:0]  shf_rx_byte = '0;
    logic [3:0]  err_clr = '0;
    logic [3:0]  err_flags;
    logic        tx_full, tx_empty, tx_req, rx_full, rx_empty, rx_req;

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0] tx_q [$];
    logic [7:0] rx_q [$];

    always #5 clk = ~clk;

    fifo_pair_trig dut (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata), .sts_word(sts_word),
        .cpu_tx_push(cpu_tx_push), .cpu_tx_byte(cpu_tx_byte),
        .cpu_rx_pop(cpu_rx_pop), .cpu_rx_byte(cpu_rx_byte),
        .shf_tx_pop(shf_tx_pop), .shf_tx_byte(shf_tx_byte),
        .shf_rx_push(shf_rx_push), .shf_rx_byte(shf_rx_byte),
        .err_clr(err_clr), .err_flags(err_flags),
        .tx_full(tx_full), .tx_empty(tx_empty), .tx_req(tx_req),
        .rx_full(rx_full), .rx_empty(rx_empty), .rx_req(rx_req)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Scoreboard monitor: compare popped heads before the consuming edge
    always @(negedge clk) begin
        if (rst_n && shf_tx_pop) begin
            if (tx_q.size() > 0) check("R2 tx order", {24'd0, shf_tx_byte}, {24'd0, tx_q.pop_front()});
            else                 check("R4 tx empty pop data", {24'd0, shf_tx_byte}, 32'd0);
        end
        if (rst_n && cpu_rx_pop) begin
            if (rx_q.size() > 0) check("R2 rx order", {24'd0, cpu_rx_byte}, {24'd0, rx_q.pop_front()});
            else                 check("R4 rx empty pop data", {24'd0, cpu_rx_byte}, 32'd0);
        end
    end

    task automatic tx_push(input logic [7:0] b);
        cpu_tx_push = 1'b1; cpu_tx_byte = b;
        if (tx_q.size() < 64) tx_q.push_back(b);
        tick();
        cpu_tx_push = 1'b0;
    endtask

    task automatic tx_pop();
        shf_tx_pop = 1'b1;
        tick();
        shf_tx_pop = 1'b0;
    endtask

    task automatic rx_push(input logic [7:0] b);
        shf_rx_push = 1'b1; shf_rx_byte = b;
        if (rx_q.size() < 64) rx_q.push_back(b);
        tick();
        shf_rx_push = 1'b0;
    endtask

    task automatic rx_pop();
        cpu_rx_pop = 1'b1;
        tick();
        cpu_rx_pop = 1'b0;
    endtask

    task automatic ctl_write(input logic [31:0] v);
        ctl_we = 1'b1; ctl_wdata = v;
        if (v[31]) tx_q.delete();
        if (v[15]) rx_q.delete();
        tick();
        ctl_we = 1'b0;
    endtask

    task automatic clr(input logic [3:0] m);
        err_clr = m;
        tick();
        err_clr = '0;
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        check("R1 status", sts_word, 32'd0);
        check("R1 control", ctl_rdata, 32'd0);
        check("R1 errors", {28'd0, err_flags}, 32'd0);
        check("R1 flags", {28'd0, tx_empty, rx_empty, tx_full, rx_full}, 32'hC);
        check("R1 R6 tx_req at level 0", {31'd0, tx_req}, 32'd1);
        check("R1 R7 rx_req at level 0", {31'd0, rx_req}, 32'd1);

        // R6 transmit request threshold
        for (int i = 0; i < 5; i++) tx_push(8'hA0 + 8'(i));
        check("R2 tx count 5", sts_word, 32'h0005_0000);
        check("R6 tx_req count5 lvl0", {31'd0, tx_req}, 32'd0);
        ctl_write(32'h0005_0000);
        check("R6 tx_req count5 lvl5", {31'd0, tx_req}, 32'd1);
        ctl_write(32'h0004_0000);
        check("R6 tx_req count5 lvl4", {31'd0, tx_req}, 32'd0);
        for (int i = 0; i < 5; i++) tx_pop();
        check("R6 tx_req drained", {31'd0, tx_req}, 32'd1);

        // R9 full, R3 overrun, R4 underrun
        for (int i = 0; i < 64; i++) tx_push(8'(i * 3 + 1));
        check("R9 tx_full at 64", {31'd0, tx_full}, 32'd1);
        check("R2 tx count 64", sts_word, 32'h0040_0000);
        tx_push(8'hEE);
        check("R3 tx overrun flag", {28'd0, err_flags}, 32'h1);
        check("R3 tx count held", sts_word, 32'h0040_0000);
        for (int i = 0; i < 64; i++) tx_pop();
        check("R9 tx_empty", {31'd0, tx_empty}, 32'd1);
        tx_pop();
        check("R4 tx underrun flag", {28'd0, err_flags}, 32'h3);
        check("R4 tx count zero", sts_word, 32'd0);

        // R5 write-one-to-clear and set priority
        clr(4'b0001);
        check("R5 clear tx ovf only", {28'd0, err_flags}, 32'h2);
        err_clr = 4'b0010; shf_tx_pop = 1'b1;
        tick();
        err_clr = '0; shf_tx_pop = 1'b0;
        check("R5 set wins over clear", {28'd0, err_flags}, 32'h2);
        clr(4'b0010);
        check("R5 cleared", {28'd0, err_flags}, 32'h0);

        // R7 receive request threshold, R10 simultaneous push/pop
        ctl_write(32'h0004_0003);
        rx_push(8'h11);
        rx_push(8'h22);
        check("R7 rx_req count2 lvl3", {31'd0, rx_req}, 32'd0);
        rx_push(8'h33);
        check("R7 rx_req count3 lvl3", {31'd0, rx_req}, 32'd1);
        check("R2 rx count 3", sts_word, 32'h0000_0003);
        shf_rx_push = 1'b1; shf_rx_byte = 8'h44; rx_q.push_back(8'h44);
        cpu_rx_pop = 1'b1;
        tick();
        shf_rx_push = 1'b0; cpu_rx_pop = 1'b0;
        check("R10 rx count unchanged", sts_word, 32'h0000_0003);
        for (int i = 0; i < 3; i++) rx_pop();
        check("R9 rx_empty", {31'd0, rx_empty}, 32'd1);

        // R8 flush behaviour
        for (int i = 0; i < 4; i++) tx_push(8'h50 + 8'(i));
        ctl_write(32'h8000_0000);
        check("R8 tx flush bit echo", ctl_rdata, 32'h8000_0000);
        tick();
        check("R8 tx flush self-clear", ctl_rdata, 32'd0);
        check("R8 tx flushed", sts_word, 32'd0);
        rx_push(8'h61);
        rx_push(8'h62);
        ctl_write(32'h0007_8000);
        check("R8 rx flush bit echo", ctl_rdata, 32'h0007_8000);
        tick();
        check("R8 rx flush self-clear", ctl_rdata, 32'h0007_0000);
        check("R8 rx flushed", sts_word, 32'd0);

        // R3/R4 on the receive queue
        for (int i = 0; i < 65; i++) rx_push(8'(255 - i));
        check("R3 rx overrun flag", {28'd0, err_flags}, 32'h4);
        check("R9 rx_full", {31'd0, rx_full}, 32'd1);
        for (int i = 0; i < 65; i++) rx_pop();
        check("R4 rx underrun flag", {28'd0, err_flags}, 32'hC);
        clr(4'b1111);
        check("R5 all cleared", {28'd0, err_flags}, 32'h0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule